// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block is a synchronous controller that brings a system up and down from a single push-button. It watches a debounced active-low button, a hold line and an enable line from the processor. It drives two regulator-enable groups: group A stays on in sleep, and group B can be switched off. It also drives an active-low button status line, an active-low reset line with a programmable stretch, and an active-low maskable interrupt line.

A press from the off state starts a boot with both groups on. The boot is kept only if the processor raises hold before the button is let go; otherwise every group is turned off again. While hold is high the system stays up. Dropping enable while the button is released puts the system to sleep, with group B off and group A on. Raising enable or pressing the button wakes it. Dropping hold at any time in the powered states turns everything off. The reset line is held low from power-up for a set number of cycles. A press during operation pulls it low at once, and it stays low until a full count has run after the release.

Top module: `pwr_btn_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the controller off: `grp_a_en`=0, `grp_b_en`=0, `rst_out_n`=0, `pb_stat_n`=1, `irq_n`=1. All interrupt sources are masked and nothing is pending.
- R2: In the off state, `btn_n`=0 at a clock edge starts a boot. Both groups are enabled from the next cycle.
- R3: In boot, the groups stay on while the button is held. If the button is released (`btn_n`=1) with `hold`=1, the system stays on. If it is released with `hold`=0, both groups are off from the next cycle.
- R4: When the system is running or asleep, `hold`=0 at a clock edge turns both groups off from the next cycle. This takes priority over every other input.
- R5: When running with `hold`=1, `en`=0 and the button released, the system enters sleep at the next cycle: `grp_a_en`=1 and `grp_b_en`=0.
- R6: In sleep with `hold`=1, either `en`=1 or `btn_n`=0 (or both) wakes the system. `grp_b_en`=1 from the next cycle.
- R7: `rst_out_n` is low in the off state. It stays low for exactly `RST_CYCLES` cycles after boot is entered, then goes high, whatever the button does during boot.
- R8: When running or asleep, `btn_n`=0 pulls `rst_out_n` low in the same cycle, with no clock edge needed. After the release it stays low for exactly `RST_CYCLES` more cycles.
- R9: `pb_stat_n` is low exactly while `btn_n`=0 and the system is running or asleep, in the same cycle. It stays high in off and boot.
- R10: Pending bit 0 latches when the button goes from released to pressed while the system is running or asleep. Pending bit 1 latches on each wake from sleep. Pending bits stay set until an `irq_clr` pulse clears them all. If a new event arrives in the same cycle as the clear, the event wins.
- R11: The mask register resets to all zeros (all masked). `irq_mask_wr`=1 loads it from `irq_mask_in`, with bit 0 for the press source and bit 1 for the wake source, and 1 meaning enabled. `irq_n` is low from the cycle after a load or event whenever any pending bit is set and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Debounced push-button, active low |
| hold | input | 1 | Processor keep-alive request |
| en | input | 1 | Processor enable for group B |
| irq_mask_wr | input | 1 | Load strobe for the mask register |
| irq_mask_in | input | 2 | Mask value, bit 0 press, bit 1 wake, 1 = enabled |
| irq_clr | input | 1 | One-cycle clear of all pending bits |
| grp_a_en | output | 1 | Always-on regulator group enable |
| grp_b_en | output | 1 | Switchable regulator group enable |
| pb_stat_n | output | 1 | Button status to the processor, active low |
| rst_out_n | output | 1 | System reset, active low |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A button press while running and an `irq_clr` pulse can land on the same clock edge. The press tries to set pending bit 0 while the clear tries to wipe it. The bench lowers `btn_n` and raises `irq_clr` together with the press source unmasked, then expects `irq_n` low in the following cycle. A wake from sleep by the button likewise sets both pending sources and reloads the reset count on one edge, and the bench judges this through `rst_out_n` and the later interrupt level.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_BOOT  = 2'd1,
      ST_ON    = 2'd2,
      ST_SLEEP = 2'd3
   } pwr_state_t;

   localparam int IRQ_SRCS  = 2;
   localparam int IRQ_PRESS = 0;
   localparam int IRQ_WAKE  = 1;
endpackage

// File: rtl/pbs_fsm.sv
module pbs_fsm
   import pbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       btn_n,
   input  logic       hold,
   input  logic       en,
   output pwr_state_t state_o,
   output logic       grp_a_en,
   output logic       grp_b_en,
   output logic       powered,
   output logic       press_evt,
   output logic       wake_evt
);
   pwr_state_t st_q, st_d;
   logic       btn_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_OFF:   if (!btn_n) st_d = ST_BOOT;
         ST_BOOT:  if (btn_n) st_d = hold ? ST_ON : ST_OFF;
         ST_ON: begin
            if (!hold)               st_d = ST_OFF;
            else if (!en && btn_n)   st_d = ST_SLEEP;
         end
         ST_SLEEP: begin
            if (!hold)               st_d = ST_OFF;
            else if (en || !btn_n)   st_d = ST_ON;
         end
         default: st_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_OFF;
         btn_q <= 1'b1;
      end else begin
         st_q  <= st_d;
         btn_q <= btn_n;
      end
   end

   assign state_o   = st_q;
   assign powered   = (st_q == ST_ON) || (st_q == ST_SLEEP);
   assign grp_a_en  = (st_q != ST_OFF);
   assign grp_b_en  = (st_q == ST_BOOT) || (st_q == ST_ON);
   assign press_evt = powered && !btn_n && btn_q;
   assign wake_evt  = (st_q == ST_SLEEP) && (st_d == ST_ON);

   assert_power_on_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_OFF && !btn_n) |=> (grp_a_en && grp_b_en));
   assert_boot_abort_R3: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_BOOT && btn_n && !hold) |=> (!grp_a_en && !grp_b_en));
   assert_boot_keep_R3: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_BOOT && btn_n && hold) |=> (st_q == ST_ON));
   assert_hold_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (powered && !hold) |=> (!grp_a_en && !grp_b_en));
   assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_ON && hold && !en && btn_n) |=> (grp_a_en && !grp_b_en));
   assert_wake_R6: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_SLEEP && hold && (en || !btn_n)) |=> grp_b_en);
endmodule

// File: rtl/pbs_rst_timer.sv
module pbs_rst_timer #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic cause,
   output logic rst_out_n
);
   localparam int CW = $clog2(RST_CYCLES + 1);

   generate
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("pbs_rst_timer: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || cause)         cnt_q <= CW'(RST_CYCLES);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

   assign rst_out_n = !(cause || (cnt_q != '0));

   assert_cause_holds_low_R7: assert property (@(posedge clk) disable iff (rst)
      cause |=> !rst_out_n);
   assert_last_count_R8: assert property (@(posedge clk) disable iff (rst)
      (!cause && cnt_q == CW'(1)) |=> (cause || rst_out_n));
endmodule

// File: rtl/pbs_irq.sv
module pbs_irq #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_evt,
   input  logic            mask_wr,
   input  logic [NSRC-1:0] mask_in,
   input  logic            clr,
   output logic            irq_n
);
   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("pbs_irq: NSRC must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0] pend_q;
   logic [NSRC-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (rst)          mask_q <= '0;
      else if (mask_wr) mask_q <= mask_in;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (rst)             pend_q[i] <= 1'b0;
         else if (src_evt[i]) pend_q[i] <= 1'b1;
         else if (clr)        pend_q[i] <= 1'b0;
      end
   end

   assign irq_n = ~|(pend_q & mask_q);

   assert_pend_stable_R10: assert property (@(posedge clk) disable iff (rst)
      (src_evt == '0 && !clr) |=> $stable(pend_q));
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      clr |=> ((pend_q & $past(src_evt)) == $past(src_evt)));
   assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      (mask_q == '0) |-> irq_n);
endmodule

// File: rtl/pwr_btn_seq.sv
module pwr_btn_seq
   import pbs_pkg::*;
#(
   parameter int RST_CYCLES = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                btn_n,
   input  logic                hold,
   input  logic                en,
   input  logic                irq_mask_wr,
   input  logic [IRQ_SRCS-1:0] irq_mask_in,
   input  logic                irq_clr,
   output logic                grp_a_en,
   output logic                grp_b_en,
   output logic                pb_stat_n,
   output logic                rst_out_n,
   output logic                irq_n
);
   pwr_state_t          state;
   logic                powered;
   logic                press_evt;
   logic                wake_evt;
   logic                rst_cause;
   logic [IRQ_SRCS-1:0] src_evt;

   pbs_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .btn_n     (btn_n),
      .hold      (hold),
      .en        (en),
      .state_o   (state),
      .grp_a_en  (grp_a_en),
      .grp_b_en  (grp_b_en),
      .powered   (powered),
      .press_evt (press_evt),
      .wake_evt  (wake_evt)
   );

   assign rst_cause = (state == ST_OFF) || (powered && !btn_n);
   assign pb_stat_n = !(powered && !btn_n);

   pbs_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .cause     (rst_cause),
      .rst_out_n (rst_out_n)
   );

   always_comb begin
      src_evt            = '0;
      src_evt[IRQ_PRESS] = press_evt;
      src_evt[IRQ_WAKE]  = wake_evt;
   end

   pbs_irq #(.NSRC(IRQ_SRCS)) u_irq (
      .clk     (clk),
      .rst     (rst),
      .src_evt (src_evt),
      .mask_wr (irq_mask_wr),
      .mask_in (irq_mask_in),
      .clr     (irq_clr),
      .irq_n   (irq_n)
   );

   assert_manual_at_once_R8: assert property (@(posedge clk) disable iff (rst)
      (grp_a_en && !grp_b_en && !btn_n) |-> (!rst_out_n && !pb_stat_n));
   assert_reset_off_R1: assert property (@(posedge clk)
      rst |=> (!grp_a_en && !grp_b_en && !rst_out_n && irq_n));
   assert_stat_boot_R9: assert property (@(posedge clk) disable iff (rst)
      (grp_b_en && !powered) |-> pb_stat_n);
endmodule

// File: tb/pwr_btn_seq_tb.sv
module pwr_btn_seq_tb_top;
   localparam int RSTC = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       btn_n = 1'b1;
   logic       hold = 1'b0;
   logic       en = 1'b0;
   logic       irq_mask_wr = 1'b0;
   logic [1:0] irq_mask_in = 2'b00;
   logic       irq_clr = 1'b0;
   logic       grp_a_en, grp_b_en, pb_stat_n, rst_out_n, irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pwr_btn_seq #(.RST_CYCLES(RSTC)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .btn_n       (btn_n),
      .hold        (hold),
      .en          (en),
      .irq_mask_wr (irq_mask_wr),
      .irq_mask_in (irq_mask_in),
      .irq_clr     (irq_clr),
      .grp_a_en    (grp_a_en),
      .grp_b_en    (grp_b_en),
      .pb_stat_n   (pb_stat_n),
      .rst_out_n   (rst_out_n),
      .irq_n       (irq_n)
   );

   // {btn_n, hold, en, exp grp_a, exp grp_b, exp pb_stat_n, exp rst_out_n}
   localparam logic [6:0] VEC [0:18] = '{
      7'b100_0010, // off, idle
      7'b000_1110, // press -> boot, reset low (R2, R7)
      7'b011_1110, // still held in boot, no status (R9)
      7'b111_1110, // release with hold -> on (R3)
      7'b111_1111, // reset count done (R7)
      7'b110_1011, // en low -> sleep (R5)
      7'b110_1011, // remain asleep
      7'b111_1111, // en high -> wake (R6)
      7'b011_1100, // press while on: status and reset low (R8, R9)
      7'b111_1110, // released, stretch 1
      7'b111_1110, // stretch 2
      7'b111_1111, // stretch done (R8)
      7'b110_1011, // sleep again (R5)
      7'b010_1100, // wake by button (R6, R8)
      7'b111_1110, // released, stretch
      7'b101_0010, // hold drops -> off (R4)
      7'b000_1110, // new boot (R2)
      7'b100_0010, // released without hold -> abort (R3)
      7'b100_0010  // stays off
   };

   task automatic chk(input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 grp_a_en", grp_a_en, 1'b0);
      chk("R1 grp_b_en", grp_b_en, 1'b0);
      chk("R1 rst_out_n", rst_out_n, 1'b0);
      chk("R1 pb_stat_n", pb_stat_n, 1'b1);
      chk("R1 irq_n", irq_n, 1'b1);

      for (int i = 0; i < 19; i++) begin
         btn_n = VEC[i][6];
         hold  = VEC[i][5];
         en    = VEC[i][4];
         tick();
         chk($sformatf("v%0d R2/R3/R4/R5/R6 grp_a_en", i), grp_a_en, VEC[i][3]);
         chk($sformatf("v%0d R2/R3/R4/R5/R6 grp_b_en", i), grp_b_en, VEC[i][2]);
         chk($sformatf("v%0d R9 pb_stat_n", i), pb_stat_n, VEC[i][1]);
         chk($sformatf("v%0d R7/R8 rst_out_n", i), rst_out_n, VEC[i][0]);
         chk($sformatf("v%0d R11 masked irq_n", i), irq_n, 1'b1);
      end

      // R11: unmask press source; press events from the table are pending
      irq_mask_in = 2'b01; irq_mask_wr = 1'b1;
      tick();
      irq_mask_wr = 1'b0;
      chk("R11 unmasked pending irq_n", irq_n, 1'b0);

      // R10: clear pulse wipes pending
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R10 clear irq_n", irq_n, 1'b1);
      irq_mask_in = 2'b11; irq_mask_wr = 1'b1;
      tick();
      irq_mask_wr = 1'b0;
      chk("R10 nothing pending after clear", irq_n, 1'b1);

      // boot to on
      btn_n = 1'b0;
      tick();
      btn_n = 1'b1; hold = 1'b1; en = 1'b1;
      tick();
      chk("R3 on after boot grp_b_en", grp_b_en, 1'b1);
      chk("R10 no press event in boot", irq_n, 1'b1);
      repeat (RSTC) tick();
      chk("R7 reset released", rst_out_n, 1'b1);

      // R8/R9 same-cycle response, and R10 set wins over clear
      btn_n = 1'b0; irq_clr = 1'b1;
      #2;
      chk("R8 rst_out_n at once", rst_out_n, 1'b0);
      chk("R9 pb_stat_n at once", pb_stat_n, 1'b0);
      tick();
      irq_clr = 1'b0;
      chk("R10 set wins over clear", irq_n, 1'b0);
      btn_n = 1'b1;
      tick();
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R10 cleared after press", irq_n, 1'b1);

      // sleep then wake by en: wake source
      en = 1'b0;
      tick();
      chk("R5 sleep grp_b_en", grp_b_en, 1'b0);
      chk("R5 sleep grp_a_en", grp_a_en, 1'b1);
      en = 1'b1;
      tick();
      chk("R6 wake grp_b_en", grp_b_en, 1'b1);
      chk("R10 wake pending irq_n", irq_n, 1'b0);

      // R1: reset from running state
      rst = 1'b1;
      tick();
      rst = 1'b0;
      chk("R1 reset from on grp_a_en", grp_a_en, 1'b0);
      chk("R1 reset from on rst_out_n", rst_out_n, 1'b0);
      chk("R1 reset from on irq_n", irq_n, 1'b1);

      finish_run();
   end
endmodule